// File: doc/BRIEF.md
# Input Pin Change-of-State Monitor

This block watches four general-purpose input pins and records any level change on each one. The pins arrive without any relation to the system clock. Each pin first passes through a synchronizer. It is then sampled only when a slow sample-enable pulse arrives. In a typical system that pulse is a 38.4 kHz tick, sixteen times a 2400 bit/s rate, so one sample period is about 26 µs. A change that stays on a pin for two sample periods is always caught. A change that lasts a single sample period is also caught, because the detector compares each new sample with the one before it.

A CPU reads one status byte. The upper nibble holds the latched change flags and the lower nibble holds the sampled pin levels. A read returns the byte in the same cycle as the read pulse and then clears the change flags only. An interrupt line is high while any change flag is set, provided the interrupt enable input is high.

Top module: `pin_change_detector`

## Requirements
- R1: After reset, the status byte reads 0x00 and `irq` is low.
- R2: Status bit n (n = 0..3) gives the level of pin n captured at the most recent sample tick, with 1 meaning high. The two-stage synchronizer adds two clock cycles of latency before a pin value can be sampled.
- R3: The first sample tick after reset only loads the levels and sets no change flag.
- R4: When a sample tick captures a level on pin n that differs from the level captured at the previous tick, status bit 4+n is set after that clock edge.
- R5: A pulse on a pin that is present at only one sample tick still sets that pin's change flag.
- R6: The change flags stay set until a read. During a one-cycle `rd_strobe`, `rd_data` shows the current byte. From the next cycle, bits 7:4 are zero unless a new change was captured.
- R7: A read leaves bits 3:0 unchanged.
- R8: A change captured in the same cycle as a read leaves that pin's flag set after the read. Flags of other pins are cleared.
- R9: `irq` is high exactly when `irq_enable` is high and at least one change flag is set.
- R10: Without a sample tick, pin activity does not change the status byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pins_async | input | 4 | Monitored pins, not synchronous to clk |
| sample_tick | input | 1 | One-cycle sample-enable pulse |
| rd_strobe | input | 1 | One-cycle CPU read pulse; clears the change flags |
| irq_enable | input | 1 | Interrupt enable |
| rd_data | output | 8 | Status byte: {change flags[3:0], levels[3:0]} |
| irq | output | 1 | Level interrupt, enabled change pending |

## Verification
The bench targets the first tick after reset. A design that compared against the reset value of the level register would flag every pin that is high at power-up. It drives a pulse seen by a single tick, which a design filtering for stable changes would miss. It issues a read in the same cycle as a new change, where a design giving the clear priority would lose the event. It also checks that a read leaves the level nibble in place, and that pin activity between ticks has no effect, which catches a sampler enabled on every clock.

// File: rtl/pcd_pkg.sv
package pcd_pkg;
  typedef enum logic {PH_COLD = 1'b0, PH_WARM = 1'b1} sample_phase_t;
endpackage

// File: rtl/pcd_sync.sv
module pcd_sync #(
  parameter int WIDTH  = 4,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  logic [STAGES-1:0][WIDTH-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
    end else begin
      chain_q[0] <= din;
      for (int i = 1; i < STAGES; i++) chain_q[i] <= chain_q[i-1];
    end
  end

  assign dout = chain_q[STAGES-1];

  // R2: the output repeats the input seen STAGES edges earlier (checked for two stages)
  p_sync_latency_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n, 2) |-> (STAGES != 2) || (dout == $past(din, 2)));
endmodule

// File: rtl/pcd_sampler.sv
module pcd_sampler
  import pcd_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sample_tick,
  input  logic [WIDTH-1:0] sync_in,
  output logic [WIDTH-1:0] level_q,
  output logic [WIDTH-1:0] delta
);
  sample_phase_t phase_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      level_q <= '0;
      phase_q <= PH_COLD;
    end else if (sample_tick) begin
      level_q <= sync_in;
      phase_q <= PH_WARM;
    end
  end

  for (genvar g = 0; g < WIDTH; g++) begin : g_pin
    assign delta[g] = sample_tick && (phase_q == PH_WARM) && (sync_in[g] != level_q[g]);
  end

  // R10: no tick, no change of the held levels
  p_hold_levels_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !sample_tick |=> $stable(level_q));
  // R2: a tick captures the synchronized pins
  p_capture_r2: assert property (@(posedge clk) disable iff (!rst_n)
    sample_tick |=> level_q == $past(sync_in));
endmodule

// File: rtl/pcd_flags.sv
module pcd_flags #(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] delta,
  input  logic             clear,
  output logic [WIDTH-1:0] flags_q
);
  function automatic logic [WIDTH-1:0] next_flags(input logic [WIDTH-1:0] cur,
                                                  input logic [WIDTH-1:0] set,
                                                  input logic             clr);
    return (clr ? '0 : cur) | set;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flags_q <= '0;
    else        flags_q <= next_flags(flags_q, delta, clear);
  end

  // R6: without a read, no flag is lost
  p_flag_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !clear |=> (flags_q & $past(flags_q)) == $past(flags_q));
  // R6: a read with no new change empties the flags
  p_flag_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (clear && delta == '0) |=> flags_q == '0);
  // R8: a change coincident with a read survives it
  p_keep_new_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (clear && delta != '0) |=> (flags_q & $past(delta)) == $past(delta));
endmodule

// File: rtl/pin_change_detector.sv
module pin_change_detector #(
  parameter int NUM_PINS    = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NUM_PINS-1:0]   pins_async,
  input  logic                  sample_tick,
  input  logic                  rd_strobe,
  input  logic                  irq_enable,
  output logic [2*NUM_PINS-1:0] rd_data,
  output logic                  irq
);
  localparam int STATUS_W = 2 * NUM_PINS;

  logic [NUM_PINS-1:0] pins_sync;
  logic [NUM_PINS-1:0] level_q;
  logic [NUM_PINS-1:0] change_evt;
  logic [NUM_PINS-1:0] flags_q;

  function automatic logic [STATUS_W-1:0] pack_status(input logic [NUM_PINS-1:0] chg,
                                                      input logic [NUM_PINS-1:0] lvl);
    return {chg, lvl};
  endfunction

  pcd_sync #(.WIDTH(NUM_PINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .din(pins_async), .dout(pins_sync)
  );

  pcd_sampler #(.WIDTH(NUM_PINS)) u_sampler (
    .clk(clk), .rst_n(rst_n), .sample_tick(sample_tick),
    .sync_in(pins_sync), .level_q(level_q), .delta(change_evt)
  );

  pcd_flags #(.WIDTH(NUM_PINS)) u_flags (
    .clk(clk), .rst_n(rst_n), .delta(change_evt), .clear(rd_strobe), .flags_q(flags_q)
  );

  assign rd_data = pack_status(flags_q, level_q);
  assign irq     = irq_enable && (|flags_q);

  // R9: disabled interrupt stays low
  p_irq_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_enable |-> !irq);
  // R9: an enabled pending change in the status byte raises the interrupt
  p_irq_on_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_enable && rd_data[STATUS_W-1:NUM_PINS] != '0) |-> irq);
  // R7: a read leaves the level nibble alone
  p_read_levels_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_strobe && !sample_tick) |=> rd_data[NUM_PINS-1:0] == $past(rd_data[NUM_PINS-1:0]));
endmodule

// File: tb/pin_change_detector_bench.sv
module pin_change_detector_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] pins_async = '0;
  logic       sample_tick = 1'b0;
  logic       rd_strobe = 1'b0;
  logic       irq_enable = 1'b0;
  logic [7:0] rd_data;
  logic       irq;

  int vectors = 0;
  int misses  = 0;
  bit done    = 0;

  always #4 clk = ~clk;

  pin_change_detector u_pin_change_detector (
    .clk(clk), .rst_n(rst_n), .pins_async(pins_async), .sample_tick(sample_tick),
    .rd_strobe(rd_strobe), .irq_enable(irq_enable), .rd_data(rd_data), .irq(irq)
  );

  // behavioural reference: pin history queue, last sample, pending events
  logic [3:0] hist[$];
  logic [3:0] m_lvl;
  logic [3:0] m_chg;
  bit         m_seen;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hist = {4'h0, 4'h0};
      m_lvl = 4'h0; m_chg = 4'h0; m_seen = 0;
    end else begin
      logic [3:0] s;
      logic [3:0] ev;
      s = hist[0];
      ev = 4'h0;
      if (sample_tick) begin
        if (m_seen) ev = s ^ m_lvl;
        m_lvl = s;
        m_seen = 1;
      end
      if (rd_strobe) m_chg = 4'h0;
      m_chg = m_chg | ev;
      void'(hist.pop_front());
      hist.push_back(pins_async);
    end
  end

  task automatic check(string tag, int act, int exp);
    vectors++;
    if (act != exp) begin
      misses++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      check("R2 level nibble vs model", rd_data[3:0], m_lvl);
      check("R4 change nibble vs model", rd_data[7:4], m_chg);
      check("R9 irq vs model", irq, irq_enable && (m_chg != 0));
    end
  end

  task automatic drive(input logic [3:0] p, input bit t, input bit r, input bit e);
    @(negedge clk);
    #1;
    pins_async = p; sample_tick = t; rd_strobe = r; irq_enable = e;
  endtask

  task automatic peek(string tag, logic [7:0] exp_b, bit exp_i);
    #1;
    check(tag, rd_data, exp_b);
    check(tag, irq, exp_i);
  endtask

  task automatic settle(input logic [3:0] p, input bit e);
    for (int i = 0; i < 3; i++) drive(p, 0, 0, e);
  endtask

  initial begin
    #2000000;
    misses++;
    $display("FAIL watchdog expired actual=hang expected=finish");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    peek("R1 reset byte during reset", 8'h00, 0);
    rst_n = 1'b1;
    drive(4'h0, 0, 0, 1);
    peek("R1 reset byte after release", 8'h00, 0);
    settle(4'b0101, 1);
    drive(4'b0101, 0, 0, 1);
    peek("R10 no tick keeps byte", 8'h00, 0);
    drive(4'b0101, 1, 0, 1);
    drive(4'b0101, 0, 0, 1);
    peek("R3 first tick loads levels only", 8'h05, 0);
    settle(4'b1100, 1);
    peek("R10 pins moved without tick", 8'h05, 0);
    drive(4'b1100, 1, 0, 1);
    drive(4'b1100, 0, 0, 1);
    peek("R4 change flags set", 8'h9C, 1);
    drive(4'b1100, 0, 0, 1);
    peek("R6 flags held without read", 8'h9C, 1);
    drive(4'b1100, 0, 1, 1);
    peek("R6 byte valid during strobe", 8'h9C, 1);
    drive(4'b1100, 0, 0, 1);
    peek("R7 read cleared flags only", 8'h0C, 0);
    settle(4'b1101, 1);
    drive(4'b1101, 1, 0, 1);
    drive(4'b1100, 0, 0, 1);
    drive(4'b1100, 0, 1, 1);
    settle(4'b1100, 1);
    drive(4'b1100, 1, 0, 1);
    drive(4'b1100, 0, 0, 1);
    peek("R5 one-tick pulse flagged", 8'h1C, 1);
    drive(4'b1100, 0, 0, 0);
    peek("R9 disabled irq low", 8'h1C, 0);
    settle(4'b1110, 1);
    drive(4'b1110, 1, 1, 1);
    drive(4'b1110, 0, 0, 1);
    peek("R8 change kept through read", 8'h2E, 1);
    for (int k = 0; k < 400; k++) begin
      logic [3:0] p;
      p = 4'((k * 7 + k / 5) % 16);
      drive(p, (k % 4) == 3, (k % 11) == 5, (k % 13) != 0);
    end
    drive(pins_async, 0, 1, 1);
    drive(pins_async, 0, 0, 1);
    peek("R6 final read empties flags", {4'h0, rd_data[3:0]}, 0);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end
endmodule